// File: doc/BRIEF.md
# Tagged Eight-Entry Register Stack

This block holds eight 80-bit operand registers for a floating-point unit. Each register holds a sign bit, a 15-bit exponent and a 64-bit significand. A 3-bit top pointer names the physical register that is currently the top of the stack. An operation can address the top itself, or any register at a distance of 0 to 7 above the top, with the sum wrapping modulo 8. That makes the same storage usable both as a push-down stack and as a set of registers addressed relative to the top.

Beside each register sits a 2-bit class tag. The tag is recomputed from the value every time the register is written, and it is set to empty when the register is popped or freed. Stack faults are found by reading these tags, not by keeping a count of occupied entries. A push onto a register that is not empty is an overflow. Using an empty register as a source is an underflow. Both faults are also reported together on an invalid-operation flag. The block does no arithmetic on the values it stores.

Top module: `tagged_reg_stack`

## Requirements
- R1: After reset the top pointer is 0, every tag is empty (tag word 16'hFFFF), and the overflow, underflow and invalid flags are 0.
- R2: A written value gets one of these tags: 01 (zero) when both exponent and significand are zero; 10 (special) when the exponent is all ones, or when the exponent is zero and the significand is not; 00 (valid) otherwise. Tag 11 means empty. Value layout: sign in bit 79, exponent in bits 78:64, significand in bits 63:0.
- R3: Push (op 3'b001) targets register top-1 mod 8. If that register is empty, the pointer moves to it and `wr_data` is stored there with its computed tag. If it is not empty, the overflow flag is raised and neither the pointer, the tags nor the data change.
- R4: Pop (op 3'b010) marks the top register empty and then adds 1 to the pointer mod 8. If the top is already empty, the underflow flag is raised and nothing changes.
- R5: `rd_data` and `rd_tag` show register (top+`rd_idx`) mod 8 combinationally. If `rd_en` is high while that register is empty, the underflow flag is raised.
- R6: Exchange (op 3'b011) swaps the data and tags of the top register and register (top+`idx`) mod 8. If either register is empty, the underflow flag is raised and nothing changes.
- R7: Write (op 3'b100) stores `wr_data` into register (top+`idx`) mod 8 with its computed tag. It never faults and does not move the pointer.
- R8: Free (op 3'b101) marks register (top+`idx`) mod 8 empty. The pointer and the other tags are unchanged.
- R9: Increment (op 3'b110) and decrement (op 3'b111) change the pointer by +1 and -1 mod 8 and leave every tag unchanged. Op 3'b000 does nothing.
- R10: Bits 2i+1:2i of `tag_word` hold the tag of physical register i. The fault flags are registered and are valid in the cycle after the operation that caused them. `invalid_op` is high exactly when overflow or underflow is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 3 | Operation code |
| idx | input | 3 | Offset from the top for exchange, write and free |
| wr_data | input | 80 | Value for push and write |
| rd_en | input | 1 | Marks the read port as used by an operand fetch |
| rd_idx | input | 3 | Offset from the top for the read port |
| rd_data | output | 80 | Value of register (top+rd_idx) |
| rd_tag | output | 2 | Tag of register (top+rd_idx) |
| top_ptr | output | 3 | Current top pointer |
| tag_word | output | 16 | All eight tags packed together |
| stk_ovf | output | 1 | Overflow flag for the previous operation |
| stk_unf | output | 1 | Underflow flag for the previous operation |
| invalid_op | output | 1 | Overflow or underflow on the previous operation |

## Verification
The bench fills all eight registers and then pushes a ninth time. A design that counted occupancy wrongly, or that stored the ninth value anyway, would either miss the overflow or overwrite the oldest entry. It pops past empty and exchanges with an empty register; a design that did not check tags first would move the pointer or corrupt a tag. It steps the pointer across the 0/7 wrap in both directions, and it feeds values that sit on each tag boundary (exponent all ones, denormal, true zero), where a classifier that mixed up its tests would report the wrong class. Random operation streams then compare the pointer, the tag word and the read data against a bench model after every step.

// File: rtl/tagged_reg_stack.sv
module tagged_reg_stack #(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64,
  parameter int DEPTH = 8,
  localparam int W  = 1 + EXP_W + SIG_W,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op,
  input  logic [PW-1:0]     idx,
  input  logic [W-1:0]      wr_data,
  input  logic              rd_en,
  input  logic [PW-1:0]     rd_idx,
  output logic [W-1:0]      rd_data,
  output logic [1:0]        rd_tag,
  output logic [PW-1:0]     top_ptr,
  output logic [2*DEPTH-1:0] tag_word,
  output logic              stk_ovf,
  output logic              stk_unf,
  output logic              invalid_op
);
  localparam logic [2:0] OP_PUSH = 3'b001, OP_POP = 3'b010, OP_XCHG = 3'b011,
                         OP_WRITE = 3'b100, OP_FREE = 3'b101, OP_INC = 3'b110,
                         OP_DEC = 3'b111;
  localparam logic [1:0] T_VALID = 2'b00, T_ZERO = 2'b01, T_SPECIAL = 2'b10, T_EMPTY = 2'b11;

  logic [W-1:0]  regs [DEPTH];
  logic [1:0]    tags [DEPTH];
  logic [PW-1:0] top;

  function automatic logic [1:0] classify(input logic [W-1:0] v);
    logic [EXP_W-1:0] e;
    logic [SIG_W-1:0] s;
    e = v[W-2 -: EXP_W];
    s = v[SIG_W-1:0];
    if (&e)                   return T_SPECIAL;
    else if (e == '0 && s == '0) return T_ZERO;
    else if (e == '0)         return T_SPECIAL;
    else                      return T_VALID;
  endfunction

  wire [PW-1:0] below  = top - PW'(1);
  wire [PW-1:0] sel    = top + idx;
  wire [PW-1:0] rd_ptr = top + rd_idx;
  wire [1:0]    new_tag = classify(wr_data);

  wire push_ok = tags[below] == T_EMPTY;
  wire pop_ok  = tags[top] != T_EMPTY;
  wire xchg_ok = tags[top] != T_EMPTY && tags[sel] != T_EMPTY;
  wire rd_unf  = rd_en && tags[rd_ptr] == T_EMPTY;

  assign rd_data    = regs[rd_ptr];
  assign rd_tag     = tags[rd_ptr];
  assign top_ptr    = top;
  assign invalid_op = stk_ovf | stk_unf;

  for (genvar g = 0; g < DEPTH; g++) begin : g_tw
    assign tag_word[2*g +: 2] = tags[g];
  end

  always_ff @(posedge clk) begin
    case (op)
      OP_PUSH:  if (push_ok) regs[below] <= wr_data;
      OP_XCHG:  if (xchg_ok) begin
                  regs[top] <= regs[sel];
                  regs[sel] <= regs[top];
                end
      OP_WRITE: regs[sel] <= wr_data;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top     <= '0;
      stk_ovf <= 1'b0;
      stk_unf <= 1'b0;
      for (int i = 0; i < DEPTH; i++) tags[i] <= T_EMPTY;
    end else begin
      stk_ovf <= op == OP_PUSH && !push_ok;
      stk_unf <= rd_unf || (op == OP_POP && !pop_ok) || (op == OP_XCHG && !xchg_ok);
      case (op)
        OP_PUSH:  if (push_ok) begin
                    top         <= below;
                    tags[below] <= new_tag;
                  end
        OP_POP:   if (pop_ok) begin
                    tags[top] <= T_EMPTY;
                    top       <= top + PW'(1);
                  end
        OP_XCHG:  if (xchg_ok) begin
                    tags[top] <= tags[sel];
                    tags[sel] <= tags[top];
                  end
        OP_WRITE: tags[sel] <= new_tag;
        OP_FREE:  tags[sel] <= T_EMPTY;
        OP_INC:   top <= top + PW'(1);
        OP_DEC:   top <= top - PW'(1);
        default: ;
      endcase
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PUSH && tags[below] != T_EMPTY) |=> stk_ovf && $stable(top) && $stable(tag_word));

  assert_push_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PUSH && tags[below] == T_EMPTY) |=> !stk_ovf && top == PW'($past(top) - PW'(1)));

  assert_pop_move_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_POP && tags[top] != T_EMPTY && !rd_unf) |=> !stk_unf && top == PW'($past(top) + PW'(1)));

  assert_pop_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_POP && tags[top] == T_EMPTY) |=> stk_unf && $stable(top) && $stable(tag_word));

  assert_incp_keeps_tags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_INC) |=> top == PW'($past(top) + PW'(1)) && $stable(tag_word));

  assert_free_keeps_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_FREE) |=> $stable(top) && !stk_ovf);
endmodule

// File: tb/tagged_reg_stack_bench.sv
module tagged_reg_stack_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  op = 0;
  logic [2:0]  idx = 0;
  logic [79:0] wr_data = 0;
  logic        rd_en = 0;
  logic [2:0]  rd_idx = 0;
  logic [79:0] rd_data;
  logic [1:0]  rd_tag;
  logic [2:0]  top_ptr;
  logic [15:0] tag_word;
  logic        stk_ovf, stk_unf, invalid_op;

  int errors = 0, checks = 0, cycles = 0;
  logic [79:0] m_data [8];
  logic [1:0]  m_tag  [8];
  int m_top;

  tagged_reg_stack u_tagged_reg_stack (.*);

  always #5 clk = ~clk;

  function automatic logic [1:0] cls(input logic [79:0] v);
    if (&v[78:64]) return 2'b10;
    if (v[78:64] == 0 && v[63:0] == 0) return 2'b01;
    if (v[78:64] == 0) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [15:0] m_word();
    logic [15:0] w;
    for (int i = 0; i < 8; i++) w[2*i +: 2] = m_tag[i];
    return w;
  endfunction

  function automatic logic [79:0] rand_val();
    logic [79:0] v = {$urandom, $urandom, $urandom};
    case ($urandom % 5)
      0: v[78:0] = '0;
      1: v[78:64] = '1;
      2: begin v[78:64] = '0; v[0] = 1'b1; end
      default: if (v[78:64] == 0 || &v[78:64]) v[70] = ~v[70];
    endcase
    return v;
  endfunction

  task automatic chk(input logic [79:0] act, input logic [79:0] exp, input string what, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] o, input int ix, input logic [79:0] d,
                      input bit ren, input int ri, input string req);
    int sel, tgt, rp;
    bit eo, eu;
    logic [79:0] td;
    logic [1:0] tt;
    @(negedge clk);
    op = o; idx = 3'(ix); wr_data = d; rd_en = ren; rd_idx = 3'(ri);
    #1;
    rp = (m_top + ri) % 8;
    chk(80'(rd_tag), 80'(m_tag[rp]), "rd_tag", "R5");
    if (m_tag[rp] != 2'b11) chk(rd_data, m_data[rp], "rd_data", "R5");
    sel = (m_top + ix) % 8;
    eo = 0;
    eu = ren && m_tag[rp] == 2'b11;
    case (o)
      3'b001: begin
        tgt = (m_top + 7) % 8;
        if (m_tag[tgt] != 2'b11) eo = 1;
        else begin m_top = tgt; m_data[tgt] = d; m_tag[tgt] = cls(d); end
      end
      3'b010: if (m_tag[m_top] == 2'b11) eu = 1;
              else begin m_tag[m_top] = 2'b11; m_top = (m_top + 1) % 8; end
      3'b011: if (m_tag[m_top] == 2'b11 || m_tag[sel] == 2'b11) eu = 1;
              else begin
                td = m_data[m_top]; tt = m_tag[m_top];
                m_data[m_top] = m_data[sel]; m_tag[m_top] = m_tag[sel];
                m_data[sel] = td; m_tag[sel] = tt;
              end
      3'b100: begin m_data[sel] = d; m_tag[sel] = cls(d); end
      3'b101: m_tag[sel] = 2'b11;
      3'b110: m_top = (m_top + 1) % 8;
      3'b111: m_top = (m_top + 7) % 8;
      default: ;
    endcase
    @(posedge clk); #1;
    chk(80'(top_ptr), 80'(m_top), "top_ptr", req);
    chk(80'(tag_word), 80'(m_word()), "tag_word", req);
    chk(80'(stk_ovf), 80'(eo), "stk_ovf", req);
    chk(80'(stk_unf), 80'(eu), "stk_unf", req);
    chk(80'(invalid_op), 80'(eo | eu), "invalid_op", "R10");
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 8; i++) begin m_tag[i] = 2'b11; m_data[i] = 'x; end
    m_top = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(80'(top_ptr), 80'(0), "reset top", "R1");
    chk(80'(tag_word), 80'(16'hFFFF), "reset tags", "R1");
    chk(80'({stk_ovf, stk_unf, invalid_op}), 80'(0), "reset flags", "R1");
    @(negedge clk); rst_n = 1;

    step(3'b001, 0, {1'b1, 15'h0, 64'h0}, 0, 0, "R2");
    chk(80'(tag_word[15:14]), 80'(2'b01), "zero tag", "R2");
    step(3'b001, 0, {1'b0, 15'h7FFF, 64'h5}, 0, 0, "R2");
    chk(80'(tag_word[13:12]), 80'(2'b10), "special tag", "R2");
    step(3'b001, 0, {1'b0, 15'h0, 64'h1}, 0, 0, "R2");
    chk(80'(tag_word[11:10]), 80'(2'b10), "denormal tag", "R2");
    step(3'b001, 0, {1'b0, 15'h3FFF, 64'h8000_0000_0000_0000}, 0, 0, "R2");
    chk(80'(tag_word[9:8]), 80'(2'b00), "valid tag", "R2");
    for (int i = 0; i < 4; i++) step(3'b001, 0, rand_val(), 1, 1, "R3");
    step(3'b001, 0, rand_val(), 0, 0, "R3");
    step(3'b011, 3, 80'h0, 1, 3, "R6");
    step(3'b100, 2, {1'b0, 15'h0, 64'h0}, 0, 2, "R7");
    step(3'b100, 5, rand_val(), 1, 5, "R7");
    for (int i = 0; i < 9; i++) step(3'b010, 0, 80'h0, 0, 0, "R4");
    step(3'b000, 0, 80'h0, 1, 4, "R5");
    step(3'b011, 1, 80'h0, 0, 0, "R6");
    step(3'b111, 0, 80'h0, 0, 0, "R9");
    step(3'b110, 0, 80'h0, 0, 0, "R9");
    step(3'b111, 0, 80'h0, 0, 0, "R9");
    step(3'b001, 0, rand_val(), 0, 0, "R3");
    step(3'b011, 0, 80'h0, 1, 0, "R6");
    step(3'b101, 0, 80'h0, 0, 0, "R8");
    step(3'b001, 0, rand_val(), 0, 0, "R3");
    step(3'b101, 6, 80'h0, 0, 0, "R8");

    for (int n = 0; n < 1500; n++) begin
      logic [2:0] o = 3'($urandom % 8);
      string r;
      case (o)
        3'b001: r = "R3"; 3'b010: r = "R4"; 3'b011: r = "R6";
        3'b100: r = "R7"; 3'b101: r = "R8"; default: r = "R9";
      endcase
      step(o, int'($urandom % 8), rand_val(), bit'($urandom % 2), int'($urandom % 8), r);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule